// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Front End

This block sits in front of a byte-writable static memory array and presents a synchronous late-write interface. On every rising clock edge it captures the address, a chip select, a global write strobe and one write strobe per byte lane. The data for a write is not sampled in the same cycle as its address. It is sampled one clock later. This removes the idle bus cycle that a read-to-write turnaround would otherwise need.

The most recent write is kept in a one-entry holding buffer. It is copied into the array only when the data phase of the next write arrives. The buffer therefore always holds the newest uncommitted data, and every read is checked against it. Each lane is resolved on its own. Lanes that were enabled in a write that has not yet been committed come from the buffer or from the data bus. The remaining lanes come from the array. Read data is registered and drives the bus in the cycle that follows the issuing edge.

The bus is modelled as separate in, out and drive-enable signals. An asynchronous output enable and an asynchronous sleep input can each release the bus at any time. Sleep also freezes the block, and the stored contents survive it.

Top module: `lw_sram_front`

## Requirements
- R1: After reset the bus is released (`dout_en` low, `dout` zero) and the holding buffer is empty.
- R2: A read (`sel_n`=0, `we_n`=1, `sleep`=0) registered at edge n drives `dout_en`=1 and the word from the most recent writes between edge n and edge n+1, provided `oe_n` is low.
- R3: For a write registered at edge n, `din` is sampled at edge n+1. Values on `din` in any other cycle do not affect stored data.
- R4: A read of the address held by the newest write returns that write's data. This also holds for a read issued in the cycle right after the write, when the data is still on `din`.
- R5: Bypass is resolved per lane. Lane i covers bits [9i+8:9i], and write strobe `be_n[i]`=0 enables it. A read returns the enabled lanes of the newest write and the older contents of the other lanes.
- R6: The buffered write reaches the array when the next write's data phase arrives. Its data stays readable after later writes to other addresses.
- R7: A write cycle with `we_n`=0 and all `be_n` bits high is aborted and changes no stored data.
- R8: A cycle with `sel_n`=1 is a deselect. It stores nothing and leaves `dout_en` low in the following cycle.
- R9: `oe_n`=1 forces `dout_en` low at once, without waiting for a clock edge. Lowering it again restores the registered read data.
- R10: While `sleep`=1, all other inputs are ignored, `dout_en` is low, and both the array and the holding buffer keep their contents.
- R11: A write cycle leaves `dout_en` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs captured on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Word address |
| sel_n | input | 1 | Synchronous chip select, active low |
| we_n | input | 1 | Global write strobe, active low |
| be_n | input | LANES | Per-lane write strobes, active low |
| din | input | LANES*LANE_W | Write data, one cycle after its address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| dout | output | LANES*LANE_W | Read data (zero when not driven) |
| dout_en | output | 1 | Bus drive enable; low means high impedance |

## Verification
The bench builds the block with a 4-bit address (16 words), four lanes and 9-bit lanes. With a small array the whole array can be filled at the start, so every lane merge can be checked against known contents. Random traffic also hits the buffered address often. This exercises back-to-back write and read hits on the same word, partial-lane overlays on committed data, and commits that overlap a read in the same edge.

// File: rtl/lw_pkg.sv
package lw_pkg;

  // Classification of the cycle captured on a clock edge
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } lw_cyc_e;

endpackage

// File: rtl/lw_cmd_stage.sv
module lw_cmd_stage
  import lw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  be_n,
  input  logic              sleep,
  output logic              rd_issue,
  output logic              data_phase,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  wr_lanes
);

  lw_cyc_e           cyc_d, cyc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  lanes_q;
  logic              cap_en;

  // decode of the cycle presented at this edge
  always_comb begin
    if (sleep)      cyc_d = CYC_IDLE;
    else if (sel_n) cyc_d = CYC_IDLE;
    else if (we_n)  cyc_d = CYC_READ;
    else            cyc_d = CYC_WRITE;
  end

  assign cap_en = (cyc_d == CYC_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= CYC_IDLE;
      addr_q  <= '0;
      lanes_q <= '0;
    end else begin
      cyc_q <= cyc_d;
      if (cap_en) begin
        addr_q  <= addr;
        lanes_q <= ~be_n;
      end
    end
  end

  assign rd_issue   = (cyc_d == CYC_READ);
  // data of the write captured last edge arrives now, unless asleep
  assign data_phase = (cyc_q == CYC_WRITE) && !sleep;
  assign wr_addr    = addr_q;
  assign wr_lanes   = lanes_q;

  // R8
  desel_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase |-> $past(!sel_n && !we_n));

endmodule

// File: rtl/lw_write_buffer.sv
module lw_write_buffer #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    data_phase,
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic [LANES-1:0]        in_lanes,
  input  logic [LANES*LANE_W-1:0] din,
  output logic                    buf_valid,
  output logic [ADDR_W-1:0]       buf_addr,
  output logic [LANES-1:0]        buf_lanes,
  output logic [LANES*LANE_W-1:0] buf_data,
  output logic                    commit_en
);

  localparam int DATA_W = LANES * LANE_W;

  logic valid_d;

  assign valid_d   = buf_valid | data_phase;
  // older entry leaves for the array as a newer one takes its place
  assign commit_en = data_phase & buf_valid & (|buf_lanes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      buf_addr  <= '0;
      buf_lanes <= '0;
      buf_data  <= {DATA_W{1'b0}};
    end else begin
      buf_valid <= valid_d;
      if (data_phase) begin
        buf_addr  <= in_addr;
        buf_lanes <= in_lanes;
        buf_data  <= din;
      end
    end
  end

  // R6
  buf_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |=> buf_valid);

  // R3
  buf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase |=> (buf_data == $past(din)));

endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic              lane_we;

    assign lane_we = wr_en & wr_lanes[g];

    always_ff @(posedge clk) begin
      if (lane_we) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
  end

endmodule

// File: rtl/lw_read_merge.sv
module lw_read_merge #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_issue,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [LANES*LANE_W-1:0] arr_data,
  input  logic                    buf_valid,
  input  logic [ADDR_W-1:0]       buf_addr,
  input  logic [LANES-1:0]        buf_lanes,
  input  logic [LANES*LANE_W-1:0] buf_data,
  input  logic                    fwd_en,
  input  logic [ADDR_W-1:0]       fwd_addr,
  input  logic [LANES-1:0]        fwd_lanes,
  input  logic [LANES*LANE_W-1:0] fwd_data,
  output logic                    rd_q,
  output logic [LANES*LANE_W-1:0] dout_q
);

  localparam int DATA_W = LANES * LANE_W;

  logic              buf_hit, fwd_hit;
  logic [DATA_W-1:0] merged;

  assign buf_hit = buf_valid && (buf_addr == rd_addr);
  assign fwd_hit = fwd_en && (fwd_addr == rd_addr);

  // newest source wins per lane: bus data, then buffer, then array
  for (genvar g = 0; g < LANES; g++) begin : g_mux
    always_comb begin
      if (fwd_hit && fwd_lanes[g])
        merged[g*LANE_W +: LANE_W] = fwd_data[g*LANE_W +: LANE_W];
      else if (buf_hit && buf_lanes[g])
        merged[g*LANE_W +: LANE_W] = buf_data[g*LANE_W +: LANE_W];
      else
        merged[g*LANE_W +: LANE_W] = arr_data[g*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      dout_q <= {DATA_W{1'b0}};
    end else begin
      rd_q <= rd_issue;
      if (rd_issue) dout_q <= merged;
    end
  end

  // R4
  fwd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue && fwd_en && (fwd_addr == rd_addr) && (&fwd_lanes))
      |=> (dout_q == $past(fwd_data)));

endmodule

// File: rtl/lw_sram_front.sv
module lw_sram_front #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        be_n,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  localparam int DATA_W = LANES * LANE_W;

  logic [1:0]        rst_sync;
  logic              rst_n_s;
  logic              rd_issue, data_phase;
  logic [ADDR_W-1:0] wr_addr;
  logic [LANES-1:0]  wr_lanes;
  logic              buf_valid, commit_en;
  logic [ADDR_W-1:0] buf_addr;
  logic [LANES-1:0]  buf_lanes;
  logic [DATA_W-1:0] buf_data, arr_data, dout_q;
  logic              rd_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  lw_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) i_cmd (
    .clk(clk), .rst_n(rst_n_s), .addr(addr), .sel_n(sel_n), .we_n(we_n),
    .be_n(be_n), .sleep(sleep), .rd_issue(rd_issue), .data_phase(data_phase),
    .wr_addr(wr_addr), .wr_lanes(wr_lanes)
  );

  lw_write_buffer #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_wbuf (
    .clk(clk), .rst_n(rst_n_s), .data_phase(data_phase), .in_addr(wr_addr),
    .in_lanes(wr_lanes), .din(din), .buf_valid(buf_valid), .buf_addr(buf_addr),
    .buf_lanes(buf_lanes), .buf_data(buf_data), .commit_en(commit_en)
  );

  lw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_arr (
    .clk(clk), .wr_en(commit_en), .wr_addr(buf_addr), .wr_lanes(buf_lanes),
    .wr_data(buf_data), .rd_addr(addr), .rd_data(arr_data)
  );

  lw_read_merge #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_merge (
    .clk(clk), .rst_n(rst_n_s), .rd_issue(rd_issue), .rd_addr(addr),
    .arr_data(arr_data), .buf_valid(buf_valid), .buf_addr(buf_addr),
    .buf_lanes(buf_lanes), .buf_data(buf_data), .fwd_en(data_phase),
    .fwd_addr(wr_addr), .fwd_lanes(wr_lanes), .fwd_data(din),
    .rd_q(rd_q), .dout_q(dout_q)
  );

  // bus release is combinational on the asynchronous controls
  assign dout_en = rd_q & ~oe_n & ~sleep;
  assign dout    = dout_en ? dout_q : {DATA_W{1'b0}};

  // R2
  read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sleep && !sel_n && we_n) |=> (dout_en || oe_n || sleep));

  // R8
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sleep && sel_n) |=> !dout_en);

  // R11
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sleep && !sel_n && !we_n) |=> !dout_en);

  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    sleep |=> !dout_en);

endmodule

// File: tb/test_lw_sram_front.sv
module test_lw_sram_front;

  localparam int CLK_P = 10;
  localparam int AW    = 4;
  localparam int L     = 4;
  localparam int LW    = 9;
  localparam int DW    = L * LW;
  localparam int WORDS = 1 << AW;
  localparam logic [DW-1:0] JUNK = 36'hA5A5A5A5A;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          sel_n, we_n, oe_n, sleep;
  logic [L-1:0]  be_n;
  logic [DW-1:0] din, dout;
  logic          dout_en;

  typedef struct {
    logic          en;
    logic [DW-1:0] d;
    string         req;
  } exp_t;

  exp_t          q[$];
  logic [DW-1:0] model_mem [WORDS];
  logic [DW-1:0] pend;
  int            total = 0;
  int            bad   = 0;
  bit            done  = 1'b0;

  lw_sram_front #(.ADDR_W(AW), .LANES(L), .LANE_W(LW)) i_lw_sram_front (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .we_n(we_n),
    .be_n(be_n), .din(din), .oe_n(oe_n), .sleep(sleep),
    .dout(dout), .dout_en(dout_en)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // kind: 0 deselect, 1 read, 2 write, 3 deselect with write strobe low
  task automatic cyc(input int kind, input int a, input logic [DW-1:0] d,
                     input logic [L-1:0] ben, input bit sl, input bit oe,
                     input string req);
    exp_t it;
    addr  = a[AW-1:0];
    sel_n = (kind == 0 || kind == 3);
    we_n  = !(kind == 2 || kind == 3);
    be_n  = ben;
    sleep = sl;
    oe_n  = oe;
    din   = pend;
    it.en  = (kind == 1) && !sl && !oe;
    it.d   = it.en ? model_mem[a[AW-1:0]] : '0;
    it.req = req;
    if (kind == 2 && !sl) begin
      for (int i = 0; i < L; i++)
        if (!ben[i]) model_mem[a[AW-1:0]][i*LW +: LW] = d[i*LW +: LW];
      pend = d;
    end else begin
      pend = JUNK;
    end
    @(posedge clk);
    q.push_back(it);
    @(negedge clk);
  endtask

  // scoreboard monitor, samples a quarter period after each edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      if (it.en) chk(dout_en === 1'b1 && dout === it.d, it.req, dout, it.d);
      else       chk(dout_en === 1'b0 && dout === '0, it.req,
                     {dout[DW-1:1], dout_en}, '0);
    end
  end

  function automatic logic [DW-1:0] rnd();
    return DW'({$urandom(), $urandom()});
  endfunction

  initial begin
    rst_n = 1'b0; addr = '0; sel_n = 1'b1; we_n = 1'b1; be_n = '1;
    din = '0; oe_n = 1'b0; sleep = 1'b0; pend = JUNK;
    repeat (3) @(posedge clk);
    #1 chk(dout_en === 1'b0 && dout === '0, "R1 in reset", {35'b0, dout_en}, '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dout_en === 1'b0, "R1 after reset", {35'b0, dout_en}, '0);

    // fill every word; write cycles never drive the bus
    for (int a = 0; a < WORDS; a++) cyc(2, a, rnd(), '0, 0, 0, "R11");
    // read everything back, last word from the buffer
    for (int a = 0; a < WORDS; a++) cyc(1, a, '0, '1, 0, 0, "R2");
    cyc(0, 0, '0, '1, 0, 0, "R8");

    // R3 R4: read the word in the cycle its data is on din
    cyc(2, 3, 36'h123456789, '0, 0, 0, "R11");
    cyc(1, 3, '0, '1, 0, 0, "R4 forward");
    cyc(1, 3, '0, '1, 0, 0, "R4 buffer");
    // R6: commit the buffer, then read it from the array
    cyc(2, 5, 36'hFEDCBA987, '0, 0, 0, "R11");
    cyc(2, 7, 36'h0F0F0F0F0, '0, 0, 0, "R11");
    cyc(1, 3, '0, '1, 0, 0, "R6 committed");
    cyc(1, 5, '0, '1, 0, 0, "R6 committed");
    cyc(1, 7, '0, '1, 0, 0, "R4 pending");

    // R5: partial-lane write, lanes 0 and 2 enabled
    cyc(2, 5, 36'h111111111, 4'b1010, 0, 0, "R11");
    cyc(1, 5, '0, '1, 0, 0, "R5 forward merge");
    cyc(0, 0, '0, '1, 0, 0, "R8");
    cyc(1, 5, '0, '1, 0, 0, "R5 buffer merge");
    cyc(2, 9, 36'h222222222, 4'b0101, 0, 0, "R11");
    cyc(1, 5, '0, '1, 0, 0, "R5 committed merge");
    cyc(1, 9, '0, '1, 0, 0, "R5 lanes 1 3");

    // R7: aborted write, then force its commit
    cyc(2, 9, 36'h333333333, 4'b1111, 0, 0, "R11");
    cyc(1, 9, '0, '1, 0, 0, "R7 pending abort");
    cyc(2, 1, 36'h444444444, '0, 0, 0, "R11");
    cyc(1, 9, '0, '1, 0, 0, "R7 after commit");

    // R8: deselect with write strobe low stores nothing
    cyc(3, 1, 36'h555555555, '0, 0, 0, "R8");
    cyc(0, 0, '0, '1, 0, 0, "R8");
    cyc(1, 1, '0, '1, 0, 0, "R8 no store");

    // R9: output enable, held and toggled mid-cycle
    cyc(1, 1, '0, '1, 0, 1, "R9 held high");
    cyc(1, 1, '0, '1, 0, 0, "R2");
    oe_n = 1'b1;
    #1 chk(dout_en === 1'b0, "R9 async release", {35'b0, dout_en}, '0);
    oe_n = 1'b0;
    #1 chk(dout_en === 1'b1 && dout === model_mem[1], "R9 async restore",
           dout, model_mem[1]);

    // R10: sleep ignores everything and keeps buffer and array
    cyc(2, 12, 36'h666666666, '0, 0, 0, "R11");
    cyc(0, 0, '0, '1, 0, 0, "R8");
    cyc(2, 12, 36'h777777777, '0, 1, 0, "R10 write ignored");
    cyc(1, 12, '0, '1, 1, 0, "R10 read ignored");
    cyc(2, 2, 36'h888888888, '0, 1, 0, "R10 write ignored");
    cyc(0, 0, '0, '1, 0, 0, "R8");
    cyc(1, 12, '0, '1, 0, 0, "R10 buffer kept");
    cyc(1, 2, '0, '1, 0, 0, "R10 array kept");

    // mixed traffic on a small array
    for (int i = 0; i < 600; i++)
      cyc($urandom_range(0, 2), $urandom_range(0, WORDS-1), rnd(),
          L'($urandom_range(0, 15)), 0, ($urandom_range(0, 7) == 0), "R5");
    for (int a = 0; a < WORDS; a++) cyc(1, a, '0, '1, 0, 0, "R6 final");
    cyc(0, 0, '0, '1, 0, 0, "R8");
    cyc(0, 0, '0, '1, 0, 0, "R8");
    @(posedge clk);
    #(CLK_P/2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule